// File: doc/BRIEF.md
# Serial Status Pin Source Controller

This block decides, on every cycle of the system clock, whether a single open-drain status pin is pulled low or released. The pin is shared between several uses. It can report the loop lock state, show that a frequency-count measurement has finished, mirror the level of one of two general I/O pins, or carry read-back data during a serial transfer.

A 3-bit code selects the source outside transfers. While chip-enable is high, the transfer direction takes over from that code. During a write transfer the pin is released. During a read transfer it carries the serial data bit. That bit is captured when chip-enable rises and again on each falling edge of the serial clock.

The count-completion source is sticky. A finished count pulls the pin low, and the pin stays low until a new count is started or a serial transfer begins. All inputs are synchronous to `clk_i`, and the output is registered, so the pin responds one clock after its inputs.

Top module: `status_pin_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `pull_o` is 0 (pin released).
- R2: With `ce_i`=0 and `sel_i`=3'b001, `pull_o` equals the value `unlock_i` had one clock earlier.
- R3: With `ce_i`=0 and `sel_i`=3'b010, a `cnt_done_i` pulse sets a sticky flag. One clock later `pull_o` is 1, and it stays 1 after the pulse ends.
- R4: A 0-to-1 change of `cnt_en_i` clears the sticky flag. Holding `cnt_en_i` high does not clear it again, so a later `cnt_done_i` still sets it.
- R5: A 0-to-1 change of `ce_i` clears the sticky flag, so the pin stays released after the transfer ends.
- R6: With `ce_i`=0, `sel_i`=3'b100 sets `pull_o` to the inverse of the previous `io1_lvl_i` when `io1_out_i`=0, and `sel_i`=3'b101 does the same with `io2_lvl_i` and `io2_out_i`. When the selected I/O has its output bit set to 1, `pull_o` is 0.
- R7: With `ce_i`=0, the codes 3'b000, 3'b011, 3'b110 and 3'b111 give `pull_o`=0.
- R8: With `ce_i`=1 and `xfer_out_i`=0 (write transfer), `pull_o` is 0 one clock later, for any code.
- R9: With `ce_i`=1 and `xfer_out_i`=1 (read transfer), `pull_o` is the inverse of a held bit. The bit loads `sdo_i` on the cycle `ce_i` rises and on each cycle where `sclk_i` goes from 1 to 0, and keeps its value otherwise.
- R10: `rel_o` is always the complement of `pull_o`.
- R11: When a clear event (count-enable rising or chip-enable rising) and `cnt_done_i` fall in the same cycle, the flag ends up cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Serial chip-enable |
| sclk_i | input | 1 | Serial clock level |
| xfer_out_i | input | 1 | Transfer direction: 1 = read (data out), 0 = write |
| sel_i | input | 3 | Pin source code |
| unlock_i | input | 1 | Loop unlock flag |
| cnt_en_i | input | 1 | Count-enable bit |
| cnt_done_i | input | 1 | Count finished strobe |
| io1_lvl_i | input | 1 | Level of I/O pin 1 |
| io2_lvl_i | input | 1 | Level of I/O pin 2 |
| io1_out_i | input | 1 | I/O pin 1 direction, 1 = output |
| io2_out_i | input | 1 | I/O pin 2 direction, 1 = output |
| sdo_i | input | 1 | Serial read-back data bit |
| pull_o | output | 1 | 1 = drive the status pin low |
| rel_o | output | 1 | 1 = release the status pin |

## Verification
The bench steps through every source code with the unlock flag and the I/O levels toggling. This shows whether each code picks the right source and whether the released codes ignore all sources. The count-completion mode is driven with a done pulse, a start with the enable held high, a second done, a transfer-triggered clear, and a start and done in the same cycle. Together these separate a sticky flag from a level pass-through and show which event wins. Write and read transfers are run over an active unlock source, with a serial clock pattern whose data changes between falling edges. This shows that the override takes precedence and that data is captured only on falling edges and at chip-enable rise.

// File: rtl/status_pin_pkg.sv
package status_pin_pkg;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned NUM_IO = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_OFF    = 3'b000,
    SRC_UNLOCK = 3'b001,
    SRC_DONE   = 3'b010,
    SRC_IO1    = 3'b100,
    SRC_IO2    = 3'b101
  } src_e;
endpackage

// File: rtl/spc_edge_det.sv
module spc_edge_det #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] sig_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sig_q[g] <= 1'b0;
      else         sig_q[g] <= sig_i[g];
    end
    assign rise_o[g] = sig_i[g] & ~sig_q[g];
    assign fall_o[g] = ~sig_i[g] & sig_q[g];
  end
endmodule

// File: rtl/spc_done_track.sv
module spc_done_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ce_rise_i,
  input  logic done_i,
  output logic flag_nxt_o,
  output logic flag_q_o
);
  logic clr;
  assign clr = start_i | ce_rise_i;

  // clear wins over done
  always_comb begin
    if (clr)         flag_nxt_o = 1'b0;
    else if (done_i) flag_nxt_o = 1'b1;
    else             flag_nxt_o = flag_q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q_o <= 1'b0;
    else         flag_q_o <= flag_nxt_o;
  end

  assert_done_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !start_i && !ce_rise_i) |=> flag_q_o);
  assert_clear_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i || ce_rise_i) |=> !flag_q_o);
  assert_flag_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !ce_rise_i && !done_i) |=> $stable(flag_q_o));
endmodule

// File: rtl/spc_sdo_hold.sv
module spc_sdo_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic sdo_i,
  output logic bit_nxt_o
);
  logic bit_q;

  assign bit_nxt_o = load_i ? sdo_i : bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bit_q <= 1'b1;
    else         bit_q <= bit_nxt_o;
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> (bit_q == $past(bit_q)));
endmodule

// File: rtl/spc_src_mux.sv
module spc_src_mux
  import status_pin_pkg::*;
#(
  parameter int unsigned IO_N = NUM_IO
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ce_i,
  input  logic             xfer_out_i,
  input  logic             unlock_i,
  input  logic             flag_i,
  input  logic [IO_N-1:0]  io_lvl_i,
  input  logic [IO_N-1:0]  io_out_i,
  input  logic             sdo_bit_i,
  output logic             pull_o
);
  logic [IO_N-1:0] io_pull;

  for (genvar g = 0; g < IO_N; g++) begin : g_io
    assign io_pull[g] = ~io_out_i[g] & ~io_lvl_i[g];
  end

  always_comb begin
    pull_o = 1'b0;
    if (ce_i) begin
      pull_o = xfer_out_i & ~sdo_bit_i;
    end else begin
      case (sel_i)
        SRC_UNLOCK: pull_o = unlock_i;
        SRC_DONE:   pull_o = flag_i;
        SRC_IO1:    pull_o = io_pull[0];
        SRC_IO2:    pull_o = io_pull[IO_N-1];
        default:    pull_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/status_pin_ctrl.sv
module status_pin_ctrl
  import status_pin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  input  logic             sclk_i,
  input  logic             xfer_out_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             unlock_i,
  input  logic             cnt_en_i,
  input  logic             cnt_done_i,
  input  logic             io1_lvl_i,
  input  logic             io2_lvl_i,
  input  logic             io1_out_i,
  input  logic             io2_out_i,
  input  logic             sdo_i,
  output logic             pull_o,
  output logic             rel_o
);
  localparam int unsigned EDGE_N = 3;
  localparam int unsigned E_CE   = 0;
  localparam int unsigned E_SCLK = 1;
  localparam int unsigned E_CNT  = 2;

  logic [EDGE_N-1:0] edge_sig, rise, fall;
  logic flag_nxt, flag_q, sdo_load, sdo_nxt, pull_d, pull_q;

  assign edge_sig = {cnt_en_i, sclk_i, ce_i};

  spc_edge_det #(.N(EDGE_N)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i (edge_sig),
    .rise_o(rise),
    .fall_o(fall)
  );

  spc_done_track u_done (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (rise[E_CNT]),
    .ce_rise_i (rise[E_CE]),
    .done_i    (cnt_done_i),
    .flag_nxt_o(flag_nxt),
    .flag_q_o  (flag_q)
  );

  assign sdo_load = rise[E_CE] | (ce_i & fall[E_SCLK]);

  spc_sdo_hold u_sdo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (sdo_load),
    .sdo_i    (sdo_i),
    .bit_nxt_o(sdo_nxt)
  );

  spc_src_mux #(.IO_N(NUM_IO)) u_mux (
    .sel_i     (sel_i),
    .ce_i      (ce_i),
    .xfer_out_i(xfer_out_i),
    .unlock_i  (unlock_i),
    .flag_i    (flag_nxt),
    .io_lvl_i  ({io2_lvl_i, io1_lvl_i}),
    .io_out_i  ({io2_out_i, io1_out_i}),
    .sdo_bit_i (sdo_nxt),
    .pull_o    (pull_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pull_q <= 1'b0;
    else         pull_q <= pull_d;
  end

  assign pull_o = pull_q;
  assign rel_o  = ~pull_q;

  assert_reset_release_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !pull_o);
  assert_unlock_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && sel_i == SRC_UNLOCK) |=> (pull_o == $past(unlock_i)));
  assert_io_out_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_i && ((sel_i == SRC_IO1 && io1_out_i) || (sel_i == SRC_IO2 && io2_out_i)))
      |=> !pull_o);
  assert_write_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && !xfer_out_i) |=> !pull_o);
  assert_ce_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ce_i) && !xfer_out_i) ##1 (!ce_i && sel_i == SRC_DONE && !cnt_done_i) |=> !pull_o);
endmodule

// File: tb/tb_status_pin_ctrl.sv
module tb_status_pin_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce = 0, sclk = 0, xout = 0, unl = 0, cte = 0, done = 0;
  logic io1 = 1, io2 = 1, io1o = 0, io2o = 0, sdo = 1;
  logic [2:0] sel = 3'b000;
  logic pull, rel;

  int compared = 0, mismatched = 0, cyc = 0;
  bit m_flag, m_ce, m_sclk, m_cte, m_hold;
  bit exp_pull = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  status_pin_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .xfer_out_i(xout),
    .sel_i(sel), .unlock_i(unl), .cnt_en_i(cte), .cnt_done_i(done),
    .io1_lvl_i(io1), .io2_lvl_i(io2), .io1_out_i(io1o), .io2_out_i(io2o),
    .sdo_i(sdo), .pull_o(pull), .rel_o(rel)
  );

  // reference model, evaluated at each rising edge
  always @(posedge clk) begin
    bit ce_r, start, sfall;
    if (!rst_n) begin
      m_flag = 0; m_ce = 0; m_sclk = 0; m_cte = 0; m_hold = 1;
      exp_pull = 0; tag = "R1";
    end else begin
      ce_r  = ce && !m_ce;
      start = cte && !m_cte;
      sfall = m_sclk && !sclk;
      if (start || ce_r) m_flag = 0;
      else if (done) m_flag = 1;
      if (ce_r || (ce && sfall)) m_hold = sdo;
      if (ce) begin
        exp_pull = xout ? !m_hold : 1'b0;
        tag = xout ? "R9" : "R8";
      end else begin
        case (sel)
          3'b001: begin exp_pull = unl; tag = "R2"; end
          3'b010: begin
            exp_pull = m_flag;
            if ((start || ce_r) && done) tag = "R11";
            else if (ce_r) tag = "R5";
            else if (start) tag = "R4";
            else tag = "R3";
          end
          3'b100: begin exp_pull = !io1o && !io1; tag = "R6"; end
          3'b101: begin exp_pull = !io2o && !io2; tag = "R6"; end
          default: begin exp_pull = 0; tag = "R7"; end
        endcase
      end
      m_ce = ce; m_sclk = sclk; m_cte = cte;
    end
  end

  always @(negedge clk) begin
    compared++;
    if (pull !== exp_pull) begin
      mismatched++;
      $display("FAIL %s: pull_o=%b expected %b (cycle %0d)", tag, pull, exp_pull, cyc);
    end
    compared++;
    if (rel !== ~exp_pull) begin
      mismatched++;
      $display("FAIL R10: rel_o=%b expected %b (cycle %0d)", rel, ~exp_pull, cyc);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected <=5000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  initial begin
    step(3);           // R1 during reset
    rst_n = 1'b1;
    step(2);           // R1 first cycle after release
    // R7: released codes ignore every source
    unl = 1; io1 = 0; io2 = 0; done = 1;
    foreach (sel[i]) ;
    sel = 3'b000; step(2);
    sel = 3'b011; step(2);
    sel = 3'b110; step(2);
    sel = 3'b111; step(2);
    done = 0;
    // R2: unlock pass-through
    sel = 3'b001;
    unl = 1; step(2); unl = 0; step(1); unl = 1; step(1); unl = 0; step(2);
    // R6: I/O sources
    sel = 3'b100; io1 = 0; step(1); io1 = 1; step(1); io1 = 0; io1o = 1; step(2); io1o = 0; step(1);
    sel = 3'b101; io2 = 0; step(1); io2 = 1; step(1); io2 = 0; io2o = 1; step(2); io2o = 0; step(1);
    io1 = 1; io2 = 1;
    // R3/R4: sticky count completion
    sel = 3'b010; step(1);
    done = 1; step(1); done = 0; step(3);     // R3 sticky low
    cte = 1; step(1); step(3);                // R4 start releases, held high
    done = 1; step(1); done = 0; step(3);     // R4 no second clear
    cte = 0; step(2);
    // R5: transfer start clears
    ce = 1; xout = 0; step(2); ce = 0; step(3);
    done = 1; step(1); done = 0; step(2);
    // R11: start and done together
    cte = 1; done = 1; step(1); done = 0; step(3);
    cte = 0; done = 1; step(1); done = 0; step(1);
    ce = 1; done = 1; step(1); done = 0; ce = 0; step(3);
    // R8: write transfer overrides unlock
    sel = 3'b001; unl = 1; step(2);
    ce = 1; xout = 0; sclk = 1; step(1); sclk = 0; step(1); sclk = 1; step(1);
    ce = 0; sclk = 0; step(2);
    // R9: read transfer, data captured at ce rise and sclk falls
    xout = 1; sdo = 0; ce = 1; step(1);
    sdo = 1; step(1);          // no edge: hold 0
    sclk = 1; step(1);         // rise: hold
    sclk = 0; step(1);         // fall: load 1
    sdo = 0; step(1);          // hold 1
    sclk = 1; step(1);
    sclk = 0; step(1);         // load 0
    sdo = 1; sclk = 1; step(1);
    sclk = 0; step(2);         // load 1
    ce = 0; xout = 0; step(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule